// File: doc/BRIEF.md
# SAR A/D Conversion Sequencer

This block is the digital side of a 10-bit successive-approximation converter. The analog sample-and-hold, the DAC and the comparator sit outside it. When the block is enabled, it waits for a start event from one selected source. That source is either a software start strobe or one of three external trigger lines. It then holds the sample switch closed for a programmable number of cycles. After that it runs ten bit decisions from MSB to LSB. In each decision it drives a trial code to the DAC and keeps or drops that bit according to the comparator.

In the final cycle the 10-bit value is written into a 16-bit result register, justified high or low, and a single-cycle done pulse is raised. While a conversion runs, a busy flag stays high no matter which source started it, and the channel captured at the start is reported. Dropping the enable aborts a conversion in progress.

Top module: `sar_adc_seq`

## Requirements
- R1: While `en` is 0 no trigger is accepted and `busy` stays 0. Clearing `en` during a conversion returns `busy` to 0 on the next clock, with no `done` pulse and no change to `result`.
- R2: `trig_sel` picks the only source that can start a conversion: 0 is `sw_start`, 1 is `ext_trig[0]`, 2 is `ext_trig[1]` and 3 is `ext_trig[2]`. Pulses on the other sources have no effect.
- R3: After a trigger is accepted at a clock edge, `busy` is 1 for exactly S + 11 cycles, where S is the sample length from R4. It then returns to 0.
- R4: The sample length is S = 2 × (`samp_code` + 1) cycles, so codes 0 to 7 give 2 to 16 cycles. `sample_hold` is 1 for exactly the first S cycles of `busy`.
- R5: In decision cycle k (k = 0..9), `dac_code` is the bits already kept with bit 9−k also set. The trial bit is kept when `cmp_in` is 1. The first decision therefore drives 0x200. With a comparator that reports `dac_code` ≤ input, the result equals the input.
- R6: With `left_just` = 1 the result sits in `result[15:6]` and `result[5:0]` is 0. With `left_just` = 0 it sits in `result[9:0]` and `result[15:10]` is 0.
- R7: `done` is 1 only in the last busy cycle and lasts one cycle. `result` changes only at the edge that begins that cycle.
- R8: A trigger that arrives while `busy` is 1 is ignored and does not lengthen or restart the conversion.
- R9: `cur_chan` takes the value of `start_chan` at the accepting edge and holds it through the conversion.
- R10: After reset, `busy`, `done`, `sample_hold`, `result` and `cur_chan` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Converter enable |
| trig_sel | input | 2 | Trigger source select |
| sw_start | input | 1 | Software start strobe (write of 1) |
| ext_trig | input | 3 | External trigger lines |
| samp_code | input | 3 | Sample-time code |
| start_chan | input | 3 | Channel to convert |
| left_just | input | 1 | Result justification, 1 = high |
| cmp_in | input | 1 | Comparator: input ≥ DAC level |
| dac_code | output | 10 | Trial code to the DAC |
| sample_hold | output | 1 | Sample switch closed |
| busy | output | 1 | Conversion in progress (start-bit readback) |
| cur_chan | output | 3 | Channel being converted |
| done | output | 1 | One-cycle completion pulse |
| result | output | 16 | Justified conversion result |

## Verification
The hardest case to reach is an abort that lands inside the bit-decision phase. The enable has to fall after sampling has ended but before the load cycle, and that window moves with the sample code. The bench counts cycles from the accepting edge with the shortest sample code and drops `en` partway through the decisions. It then checks that the result from the earlier conversion is still held. Triggers that arrive while busy are handled the same way: the bench fires one a few cycles into a conversion and confirms that the busy length still matches the configured sample count.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_SAMP, PH_CONV, PH_LOAD} phase_t;

  // sample length in conversion clocks for a given code
  function automatic int unsigned samp_len(input logic [2:0] code);
    return 2 * (int'(code) + 1);
  endfunction
endpackage

// File: rtl/adc_trig_sel.sv
module adc_trig_sel #(
  parameter int NSRC  = 4,
  parameter int SEL_W = $clog2(NSRC)
) (
  input  logic             sw_start,
  input  logic [NSRC-2:0]  ext_trig,
  input  logic [SEL_W-1:0] sel,
  output logic             hit
);
  logic [NSRC-1:0] srcs;
  assign srcs = {ext_trig, sw_start};
  assign hit  = srcs[sel];
endmodule

// File: rtl/adc_sar_reg.sv
module adc_sar_reg #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic             cmp_in,
  output logic [RES_W-1:0] trial,
  output logic [RES_W-1:0] decided,
  output logic             last
);
  logic [RES_W-1:0] kept, ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kept <= '0;
      ptr  <= '0;
    end else if (clear) begin
      kept <= '0;
      ptr  <= RES_W'(1) << (RES_W - 1);
    end else if (step) begin
      if (cmp_in) kept <= kept | ptr;
      ptr <= ptr >> 1;
    end
  end

  assign trial   = kept | ptr;
  assign decided = cmp_in ? (kept | ptr) : kept;
  assign last    = ptr[0];

  // R5: exactly one trial bit is under test in each decision cycle
  a_r5_one_trial_bit: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> $onehot(ptr));
  // R5: the bit under test is never one already kept
  a_r5_trial_fresh: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> ((kept & ptr) == '0));
endmodule

// File: rtl/adc_result_reg.sv
module adc_result_reg #(
  parameter int RES_W = 10,
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             left,
  input  logic [RES_W-1:0] din,
  output logic [OUT_W-1:0] dout
);
  localparam int PAD = OUT_W - RES_W;

  function automatic logic [OUT_W-1:0] justify(input logic [RES_W-1:0] v, input logic hi);
    return OUT_W'(v) << (hi ? PAD : 0);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dout <= '0;
    else if (load) dout <= justify(din, left);
  end

  // R6: either the top or the bottom pad field is always clear
  a_r6_pad_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (dout[OUT_W-1:RES_W] == '0) || (dout[PAD-1:0] == '0));
  // R7: the register moves only on a load
  a_r7_only_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dout) |-> $past(load));
endmodule

// File: rtl/sar_adc_seq.sv
module sar_adc_seq
  import sar_seq_pkg::*;
#(
  parameter int RES_W   = 10,
  parameter int OUT_W   = 16,
  parameter int CHAN_W  = 3,
  parameter int SCODE_W = 3,
  parameter int NSRC    = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic [$clog2(NSRC)-1:0] trig_sel,
  input  logic                    sw_start,
  input  logic [NSRC-2:0]         ext_trig,
  input  logic [SCODE_W-1:0]      samp_code,
  input  logic [CHAN_W-1:0]       start_chan,
  input  logic                    left_just,
  input  logic                    cmp_in,
  output logic [RES_W-1:0]        dac_code,
  output logic                    sample_hold,
  output logic                    busy,
  output logic [CHAN_W-1:0]       cur_chan,
  output logic                    done,
  output logic [OUT_W-1:0]        result
);
  localparam int CNT_W = $clog2(2 * (1 << SCODE_W) + 1);

  phase_t            phase;
  logic [CNT_W-1:0]  cnt;
  logic              trig_hit, accept, sar_step, sar_last, res_load;
  logic [RES_W-1:0]  sar_decided;

  adc_trig_sel #(.NSRC(NSRC)) u_trig (
    .sw_start(sw_start), .ext_trig(ext_trig), .sel(trig_sel), .hit(trig_hit)
  );

  assign accept   = en && (phase == PH_IDLE) && trig_hit;
  assign sar_step = en && (phase == PH_CONV);
  assign res_load = sar_step && sar_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      cur_chan <= '0;
    end else if (!en) begin
      phase <= PH_IDLE;
    end else begin
      unique case (phase)
        PH_IDLE: if (trig_hit) begin
          phase    <= PH_SAMP;
          cnt      <= CNT_W'(samp_len(samp_code) - 1);
          cur_chan <= start_chan;
        end
        PH_SAMP: if (cnt == '0) phase <= PH_CONV;
                 else           cnt   <= cnt - 1'b1;
        PH_CONV: if (sar_last) phase <= PH_LOAD;
        PH_LOAD: phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  adc_sar_reg #(.RES_W(RES_W)) u_sar (
    .clk(clk), .rst_n(rst_n), .clear(accept), .step(sar_step), .cmp_in(cmp_in),
    .trial(dac_code), .decided(sar_decided), .last(sar_last)
  );

  adc_result_reg #(.RES_W(RES_W), .OUT_W(OUT_W)) u_res (
    .clk(clk), .rst_n(rst_n), .load(res_load), .left(left_just),
    .din(sar_decided), .dout(result)
  );

  assign busy        = (phase != PH_IDLE);
  assign sample_hold = (phase == PH_SAMP);
  assign done        = (phase == PH_LOAD);

  // R1: enable low forces idle on the next edge
  a_r1_abort: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy);
  // R1: a start needs enable at the accepting edge
  a_r1_start_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(en));
  // R4: sampling happens only inside a conversion
  a_r4_hold_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    sample_hold |-> busy);
  // R7: done is a single-cycle pulse
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R3: busy ends right after the done cycle
  a_r3_end_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  // R9: channel held while busy
  a_r9_chan_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cur_chan));
endmodule

// File: tb/sim_sar_adc_seq.sv
module sim_sar_adc_seq;
  localparam int PERIOD = 10;

  logic        clk = 0, rst_n = 0, en = 0, sw_start = 0, left_just = 0;
  logic [1:0]  trig_sel = 0;
  logic [2:0]  ext_trig = 0, samp_code = 0, start_chan = 0, cur_chan;
  logic [9:0]  dac_code, vin = 0;
  logic        cmp_in, sample_hold, busy, done;
  logic [15:0] result, held;
  int          nvec = 0, nbad = 0;

  always #(PERIOD/2) clk = ~clk;
  assign cmp_in = (dac_code <= vin);

  sar_adc_seq u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .trig_sel(trig_sel), .sw_start(sw_start),
    .ext_trig(ext_trig), .samp_code(samp_code), .start_chan(start_chan),
    .left_just(left_just), .cmp_in(cmp_in), .dac_code(dac_code),
    .sample_hold(sample_hold), .busy(busy), .cur_chan(cur_chan), .done(done),
    .result(result)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fire(input int src, input bit v);
    if (src == 0) sw_start = v;
    else ext_trig[src-1] = v;
  endtask

  // one full conversion; retrig fires the selected source while busy
  task automatic run_conv(input int src, input int code, input int chan,
                          input bit left, input int val, input bit retrig);
    int n = 2 * (code + 1);
    int cnt = 0, sh = 0, dn = 0, didx = -1, dfirst = 0;
    logic [15:0] res = 0, exp;
    bit chanbad = 0;
    en = 1; trig_sel = 2'(src); samp_code = 3'(code); start_chan = 3'(chan);
    left_just = left; vin = 10'(val);
    @(negedge clk); fire(src, 1);
    @(negedge clk); fire(src, 0); start_chan = ~3'(chan);
    while (busy && cnt < 64) begin
      if (cnt == n) dfirst = int'(dac_code);
      if (sample_hold) sh++;
      if (done) begin dn++; didx = cnt; res = result; end
      if (cur_chan != 3'(chan)) chanbad = 1;
      if (retrig && cnt == 3) fire(src, 1);
      if (retrig && cnt == 4) fire(src, 0);
      cnt++;
      @(negedge clk);
    end
    fire(src, 0);
    exp = left ? (16'(val) << 6) : 16'(val);
    chk(cnt == n + 11, retrig ? "R8 busy length with retrigger" : "R3 busy length", cnt, n + 11);
    chk(sh == n, "R4 sample length", sh, n);
    chk(dn == 1 && didx == n + 10, "R7 done position", didx, n + 10);
    chk(dfirst == 512, "R5 first trial code", dfirst, 512);
    chk(res == exp, left ? "R5 R6 left result" : "R5 R6 right result", int'(res), int'(exp));
    chk(!chanbad, "R9 channel capture", int'(cur_chan), chan);
    chk(result == exp, "R7 result held after done", int'(result), int'(exp));
  endtask

  initial begin
    #(PERIOD * 150000);
    nbad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    int vals[6] = '{0, 1023, 512, 511, 341, 682};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk(!busy && !done && !sample_hold, "R10 reset flags", {busy, done, sample_hold}, 0);
    chk(result == 0 && cur_chan == 0, "R10 reset result/chan", int'(result), 0);

    // R1: triggers ignored while disabled
    en = 0; trig_sel = 0;
    @(negedge clk); sw_start = 1;
    @(negedge clk); sw_start = 0;
    chk(!busy, "R1 disabled trigger ignored", busy, 0);

    // sweep codes, sources, values, justification
    for (int c = 0; c < 8; c++)
      for (int s = 0; s < 4; s++)
        for (int v = 0; v < 6; v++)
          run_conv(s, c, (c + s + v) % 8, bit'((v + s) % 2), (vals[v] + 37 * c) % 1024, 1'b0);

    // R8 retrigger while busy
    run_conv(0, 3, 5, 1'b1, 777, 1'b1);
    run_conv(2, 0, 2, 1'b0, 100, 1'b1);

    // R2: unselected sources do nothing (selected = ext_trig[1])
    en = 1; trig_sel = 2;
    for (int s = 0; s < 4; s++) begin
      if (s == 2) continue;
      @(negedge clk); fire(s, 1);
      @(negedge clk); fire(s, 0);
      chk(!busy, "R2 unselected source ignored", busy, 0);
    end

    // R1 abort during sampling
    held = result;
    trig_sel = 0; samp_code = 7; vin = 900;
    @(negedge clk); sw_start = 1;
    @(negedge clk); sw_start = 0;
    repeat (4) @(negedge clk);
    chk(busy, "R1 busy before abort", busy, 1);
    en = 0;
    @(negedge clk);
    chk(!busy && !done, "R1 abort clears busy", busy, 0);
    chk(result == held, "R1 abort keeps result", int'(result), int'(held));

    // R1 abort during bit decisions (S=2, cut at cycle 6)
    en = 1; samp_code = 0; vin = 5;
    @(negedge clk); sw_start = 1;
    @(negedge clk); sw_start = 0;
    repeat (6) @(negedge clk);
    chk(busy && !sample_hold, "R1 in decision phase", busy, 1);
    en = 0;
    @(negedge clk);
    chk(!busy, "R1 abort in decisions clears busy", busy, 0);
    repeat (12) begin
      chk(!done && result == held, "R1 no completion after abort", int'(result), int'(held));
      @(negedge clk);
    end

    // conversion works again after re-enable
    run_conv(1, 1, 6, 1'b0, 1000, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule